// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds eight 80-bit operand registers for a floating-point unit. The instruction stream reaches them as a stack. A 3-bit top pointer picks the physical register behind ST(0), and a relative index i reaches ST(i) = register (top + i) mod 8. Pushes move the pointer down and pops move it up, and both wrap around the ring.

Each register carries a valid tag. A push that would land on a live register is refused and reported as an overflow. A pop, a read or a combine that touches an empty register is refused and reported as an underflow. Either fault leaves the stack exactly as it was.

The block also serves the implicit two-operand arithmetic form. ST(0) and ST(1) are always visible on two read ports. An outside datapath computes the result. The combine operation writes that result into ST(1) and pops in the same cycle, so the result ends up as the new ST(0). The current pointer value is an output, so it can be packed into a status word.

Top module: `fstk_ctrl`

## Requirements
- R1: After reset the pointer reads 0, both fault outputs are low, and every register is empty, so a READ of any ST(i) reports underflow.
- R2: PUSH (op code 1) onto an empty slot moves the pointer to (top - 1) mod 8, so 0 wraps to 7. It writes the input data into the new ST(0) and marks that slot valid.
- R3: PUSH when register (top - 1) mod 8 is valid raises the overflow output for the following cycle. The pointer and the register contents do not change.
- R4: POP (op code 2) of a valid ST(0) shows ST(0) on the A read port during the request cycle. It then marks that register empty and moves the pointer to (top + 1) mod 8, so 7 wraps to 0.
- R5: The A read port always shows register (top + idx) mod 8, and the B read port always shows register (top + 1) mod 8, which is ST(1).
- R6: READ (op code 3) of an empty ST(idx), or POP of an empty ST(0), raises the underflow output for the following cycle and changes no state.
- R7: WRITE (op code 4) stores the input data into ST(idx) and marks it valid. The pointer does not move.
- R8: COMBINE (op code 5) needs ST(0) and ST(1) both valid. It then writes the input data into register (top + 1) mod 8, marks the old top empty, and moves the pointer up by one. If either slot is empty it raises underflow and changes no state.
- R9: Op code 0 and codes 6 and 7 do nothing. The fault outputs are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code for this cycle |
| idx_i | input | 3 | Relative index i for READ and WRITE, and for the A read port |
| wdata_i | input | 80 | Data for PUSH, WRITE and COMBINE |
| rda_o | output | 80 | Contents of ST(idx_i) |
| rdb_o | output | 80 | Contents of ST(1) |
| top_o | output | 3 | Current top-of-stack pointer |
| ovf_o | output | 1 | Stack overflow pulse, one cycle after the request |
| unf_o | output | 1 | Stack underflow pulse, one cycle after the request |

## Verification
A wrong pointer shows on top_o on the first clock after the faulty operation. It also moves every ST(i) seen on rda_o and rdb_o at once. A wrong tag stays hidden until an operation touches that slot: the next PUSH, POP, READ or COMBINE that reaches it raises a fault pulse, or fails to raise one, one cycle later. The bench therefore follows each stack change with reads at several depths and fills and drains the ring past both wrap points, so that tag and pointer errors become visible at the ports.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4,
    OP_FOLD  = 3'd5
  } stk_op_e;

  // physical slot of a relative position on a ring of n registers
  function automatic int unsigned ring_slot(input int unsigned top,
                                            input int unsigned rel,
                                            input int unsigned n);
    return (top + rel) % n;
  endfunction

  // slot one below the top on the ring (push target)
  function automatic int unsigned ring_below(input int unsigned top,
                                             input int unsigned n);
    return (top + n - 1) % n;
  endfunction

endpackage

// File: rtl/fstk_tagfile.sv
module fstk_tagfile #(
  parameter int NREG = 8,
  parameter int PW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [PW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [PW-1:0]   clr_idx,
  output logic [NREG-1:0] valid_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        valid_o[g] <= 1'b0;
      else if (set_en && set_idx == PW'(g))
        valid_o[g] <= 1'b1;
      else if (clr_en && clr_idx == PW'(g))
        valid_o[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/fstk_datafile.sv
module fstk_datafile #(
  parameter int NREG = 8,
  parameter int DW   = 80,
  parameter int PW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] ra_idx,
  input  logic [PW-1:0] rb_idx,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && widx == PW'(g))
        mem[g] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];

endmodule

// File: rtl/fstk_ctrl.sv
module fstk_ctrl #(
  parameter int NREG = 8,
  parameter int DW   = 80,
  localparam int PW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic [PW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rda_o,
  output logic [DW-1:0] rdb_o,
  output logic [PW-1:0] top_o,
  output logic          ovf_o,
  output logic          unf_o
);
  import fstk_pkg::*;

  logic [PW-1:0]   top_q, top_d;
  logic [NREG-1:0] valid;
  logic [PW-1:0]   slot_a, slot_up, slot_dn;

  // named internal events
  logic is_push, is_pop, is_read, is_write, is_fold;
  logic push_ok, push_ovf, pop_ok, pop_unf, read_unf, fold_ok, fold_unf;
  logic wr_en, clr_en;
  logic [PW-1:0] wr_idx;
  logic ovf_q, unf_q;

  assign slot_a  = PW'(ring_slot(int'(top_q), int'(idx_i), NREG));
  assign slot_up = PW'(ring_slot(int'(top_q), 1, NREG));
  assign slot_dn = PW'(ring_below(int'(top_q), NREG));

  assign is_push  = (op_i == OP_PUSH);
  assign is_pop   = (op_i == OP_POP);
  assign is_read  = (op_i == OP_READ);
  assign is_write = (op_i == OP_WRITE);
  assign is_fold  = (op_i == OP_FOLD);

  assign push_ovf = is_push &&  valid[slot_dn];
  assign push_ok  = is_push && !valid[slot_dn];
  assign pop_unf  = is_pop  && !valid[top_q];
  assign pop_ok   = is_pop  &&  valid[top_q];
  assign read_unf = is_read && !valid[slot_a];
  assign fold_ok  = is_fold &&  valid[top_q] && valid[slot_up];
  assign fold_unf = is_fold && !fold_ok;

  assign wr_en  = push_ok || is_write || fold_ok;
  assign clr_en = pop_ok || fold_ok;

  always_comb begin
    if (push_ok)       wr_idx = slot_dn;
    else if (is_write) wr_idx = slot_a;
    else               wr_idx = slot_up;
  end

  always_comb begin
    top_d = top_q;
    if (push_ok)               top_d = slot_dn;
    else if (pop_ok || fold_ok) top_d = slot_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      top_q <= top_d;
      ovf_q <= push_ovf;
      unf_q <= pop_unf || read_unf || fold_unf;
    end
  end

  fstk_tagfile #(.NREG(NREG), .PW(PW)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (wr_en),
    .set_idx (wr_idx),
    .clr_en  (clr_en),
    .clr_idx (top_q),
    .valid_o (valid)
  );

  fstk_datafile #(.NREG(NREG), .DW(DW), .PW(PW)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .widx    (wr_idx),
    .wdata   (wdata_i),
    .ra_idx  (slot_a),
    .rb_idx  (slot_up),
    .ra_data (rda_o),
    .rb_data (rdb_o)
  );

  assign top_o = top_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  // R2
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (top_q == $past(top_q) - PW'(1)) && valid[top_q]);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ovf |=> (top_q == $past(top_q)) && ovf_o && (valid == $past(valid)));

  // R4
  pop_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (top_q == $past(top_q) + PW'(1)) && !valid[$past(top_q)]);

  // R6
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_unf || read_unf) |=> unf_o && $stable(top_q) && $stable(valid));

  // R8
  fold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_ok |=> valid[top_q] && (top_q == $past(top_q) + PW'(1)) && (rda_o == $past(wdata_i) || idx_i != '0));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

endmodule

// File: tb/fstk_ctrl_bench.sv
`timescale 1ns/1ps
module fstk_ctrl_bench;
  import fstk_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [2:0]  idx_i = 3'd0;
  logic [79:0] wdata_i = '0;
  logic [79:0] rda_o, rdb_o;
  logic [2:0]  top_o;
  logic        ovf_o, unf_o;

  fstk_ctrl u_fstk_ctrl (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i), .wdata_i(wdata_i),
    .rda_o(rda_o), .rdb_o(rdb_o), .top_o(top_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] top;
    logic       ovf;
    logic       unf;
    string      req;
  } exp_t;
  exp_t sb[$];

  // independent reference state
  logic [79:0] m_reg [8];
  bit          m_val [8];
  int          m_top = 0;

  function automatic logic [79:0] pat(input int n);
    return {16'hC0DE, 32'(n * 7 + 3), 32'(~n)};
  endfunction

  task automatic chk_data(input logic [79:0] got, input logic [79:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s data got %h exp %h", req, got, exp);
    end
  endtask

  // driver: drives one op, checks combinational reads, queues the post-edge expectation
  task automatic do_op(input logic [2:0] op, input int idx, input logic [79:0] d, input string req);
    exp_t e;
    int dn, up, sa;
    @(negedge clk);
    op_i = op; idx_i = 3'(idx); wdata_i = d;
    #1;
    dn = (m_top + 7) % 8;
    up = (m_top + 1) % 8;
    sa = (m_top + idx) % 8;
    e.ovf = 1'b0; e.unf = 1'b0; e.req = req;
    if (m_val[sa]) chk_data(rda_o, m_reg[sa], {req, " R5 port A"});
    if (m_val[up]) chk_data(rdb_o, m_reg[up], {req, " R5 port B"});
    case (op)
      OP_PUSH:  if (m_val[dn]) e.ovf = 1'b1;
                else begin m_top = dn; m_reg[dn] = d; m_val[dn] = 1; end
      OP_POP:   if (!m_val[m_top]) e.unf = 1'b1;
                else begin m_val[m_top] = 0; m_top = up; end
      OP_READ:  if (!m_val[sa]) e.unf = 1'b1;
      OP_WRITE: begin m_reg[sa] = d; m_val[sa] = 1; end
      OP_FOLD:  if (!(m_val[m_top] && m_val[up])) e.unf = 1'b1;
                else begin m_reg[up] = d; m_val[up] = 1; m_val[m_top] = 0; m_top = up; end
      default: ;
    endcase
    e.top = 3'(m_top);
    sb.push_back(e);
  endtask

  // monitor: compares registered outputs just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (top_o !== e.top || ovf_o !== e.ovf || unf_o !== e.unf) begin
        errors++;
        $display("FAIL %s top/ovf/unf got %0d/%0b/%0b exp %0d/%0b/%0b",
                 e.req, top_o, ovf_o, unf_o, e.top, e.ovf, e.unf);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_reg[k] = '0; m_val[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (top_o !== 3'd0 || ovf_o !== 1'b0 || unf_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset got %0d/%0b/%0b exp 0/0/0", top_o, ovf_o, unf_o);
    end
    rst_n = 1'b1;
    do_op(OP_READ, 3, '0, "R1 empty read");
    do_op(OP_POP, 0, '0, "R6 empty pop");
    do_op(OP_NOP, 0, '0, "R9 flags drop");
    do_op(OP_PUSH, 0, pat(1), "R2 push wrap 0->7");
    do_op(OP_PUSH, 0, pat(2), "R2 push");
    do_op(OP_PUSH, 0, pat(3), "R2 push");
    for (int i = 0; i < 4; i++) do_op(OP_READ, i, '0, "R5 read depth");
    do_op(OP_WRITE, 2, pat(40), "R7 write ST2");
    do_op(OP_READ, 2, '0, "R7 readback");
    do_op(OP_WRITE, 5, pat(41), "R7 write empty slot");
    do_op(OP_READ, 5, '0, "R7 readback empty slot");
    for (int i = 4; i < 8; i++) do_op(OP_PUSH, 0, pat(i), "R2 fill");
    do_op(OP_PUSH, 0, pat(99), "R3 overflow");
    do_op(OP_READ, 0, '0, "R3 contents kept");
    do_op(OP_PUSH, 0, pat(98), "R3 overflow again");
    do_op(OP_FOLD, 0, pat(50), "R8 combine");
    do_op(OP_READ, 0, '0, "R8 result is ST0");
    do_op(OP_NOP, 0, '0, "R9 nop");
    do_op(3'd6, 1, pat(77), "R9 unused code");
    do_op(3'd7, 1, pat(78), "R9 unused code");
    for (int i = 0; i < 8; i++) do_op(OP_POP, 0, '0, "R4 drain with wrap 7->0");
    do_op(OP_FOLD, 0, pat(51), "R8 combine on empty");
    do_op(OP_PUSH, 0, pat(60), "R2 single push");
    do_op(OP_FOLD, 0, pat(52), "R8 combine one valid");
    do_op(OP_READ, 1, '0, "R6 read empty ST1");
    do_op(OP_PUSH, 0, pat(61), "R2 second push");
    do_op(OP_FOLD, 0, pat(53), "R8 combine two valid");
    do_op(OP_POP, 0, '0, "R4 pop result");
    do_op(OP_POP, 0, '0, "R6 pop empty again");
    do_op(OP_NOP, 0, '0, "R9 idle");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule